// File: doc/BRIEF.md
# Funnel double-word shift unit

This unit shifts one data word left or right by 0 to 63 bit positions. Plain shifters fill the vacated positions with zeros. This one fills them from a second operand, the fill word. The bits pushed out of the data word are returned as a second result, the spill word. A wide integer held as several words is shifted by running one unit per word. Each word's spill is fed as the fill of its neighbour: the next-higher word for a left shift, the next-lower word for a right shift.

All results are registered and appear one clock after the inputs are sampled. An overflow flag reports any nonzero spill. When recording is enabled, a 4-bit condition field is loaded. It classifies the merged result as negative, positive or zero in two's complement and copies a summary-overflow input. When recording is off, the field keeps its earlier value.

Top module: `funnel_shift_unit`

## Requirements
- R1: A synchronous active-high reset clears `result_o`, `spill_o`, `ovf_o` and `cond_o` to zero on the clock edge where it is sampled high.
- R2: Only bits [5:0] of `amt_i` form the shift count n, and the upper bits have no effect. Every result reflects the inputs sampled at the previous rising clock edge.
- R3: When shifting left (`dir_right_i`=0), `result_o` holds `data_i` shifted left by n in bits [63:n], and bits [n-1:0] of `fill_i` at their own positions in bits [n-1:0].
- R4: When shifting left, `spill_o` holds the top n bits of `data_i` in its bits [n-1:0], and every other bit is zero.
- R5: When shifting right (`dir_right_i`=1), `result_o` holds `data_i` shifted right by n in bits [63-n:0], and bits [63:64-n] of `fill_i` at their own positions in the top n bits.
- R6: When shifting right, `spill_o` holds the bottom n bits of `data_i` in its bits [63:64-n], and every other bit is zero.
- R7: `ovf_o` is 1 exactly when `spill_o` is nonzero.
- R8: With n = 0, in either direction, `result_o` equals `data_i`, `spill_o` is zero and `ovf_o` is 0.
- R9: When `rec_en_i` is 1, `cond_o` is loaded as follows. Bit 3 is set if `result_o` is negative as a signed value. Bit 2 is set if it is positive. Bit 1 is set if it is zero. Bit 0 is a copy of `so_i`.
- R10: When `rec_en_i` is 0, `cond_o` keeps its previous value.
- R11: Four units chained through their spill and fill words shift a 256-bit value by any n from 0 to 63 in either direction, with zeros entering at the outer end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 64 | Word to be shifted |
| amt_i | input | 64 | Shift-count word; only bits [5:0] are used |
| fill_i | input | 64 | Word that supplies the vacated bit positions |
| dir_right_i | input | 1 | 0 shifts left, 1 shifts right |
| rec_en_i | input | 1 | Loads the condition field when 1 |
| so_i | input | 1 | Summary-overflow bit copied into the condition field |
| result_o | output | 64 | Merged shifted word |
| spill_o | output | 64 | Bits shifted out of the data word |
| ovf_o | output | 1 | Set when the spill word is nonzero |
| cond_o | output | 4 | Condition field {negative, positive, zero, summary overflow} |

## Verification
Every result of this unit, including the merged word, the spill word, the overflow flag and the condition field, is due exactly one rising edge after its inputs are driven. The bench changes inputs just after a rising edge. It samples the outputs just after the following rising edge, and compares them with a behavioural wide-shift model evaluated on the inputs driven for that edge. The condition field is checked against a model state that changes only in cycles with recording enabled. This exposes a field that was overwritten when it should have been held. The 256-bit chain takes two edges: the first produces every word's spill, and the second merges each spill into its neighbour as the fill.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int unsigned FSH_DEF_W = 64;

    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } sh_dir_e;

    // Condition field, most significant member first
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    function automatic cond_t cond_from(input logic neg, input logic zero, input logic so);
        cond_t c;
        c.lt = neg;
        c.gt = !neg && !zero;
        c.eq = zero;
        c.so = so;
        return c;
    endfunction

endpackage

// File: rtl/fsh_rotl.sv
// Logarithmic left rotator: one stage per count bit.
module fsh_rotl #(
    parameter int unsigned W  = fsh_pkg::FSH_DEF_W,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:AW];

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned SH = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
                                   : stage[s];
    end

    assign dout = stage[AW];
endmodule

// File: rtl/fsh_mask.sv
// Keep-mask: 1 where the rotated data word survives, 0 where fill is merged in.
module fsh_mask #(
    parameter int unsigned W  = fsh_pkg::FSH_DEF_W,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [AW-1:0]      n,
    input  fsh_pkg::sh_dir_e   dir,
    output logic [W-1:0]       keep
);
    import fsh_pkg::*;

    localparam logic [AW:0] WV = (AW+1)'(W);
    logic [AW:0] n_ext;

    assign n_ext = {1'b0, n};

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [AW:0] IDX = (AW+1)'(i);
        logic above_n;
        logic below_top;
        assign above_n   = (IDX >= n_ext);
        assign below_top = ((IDX + n_ext) < WV);
        assign keep[i]   = (dir == SH_LEFT) ? above_n : below_top;
    end
endmodule

// File: rtl/fsh_flags.sv
// Overflow and condition-field candidate from the merged and spilled words.
module fsh_flags #(
    parameter int unsigned W = fsh_pkg::FSH_DEF_W
) (
    input  logic [W-1:0]    merged,
    input  logic [W-1:0]    spilled,
    input  logic            so,
    output logic            ovf,
    output fsh_pkg::cond_t  cond
);
    import fsh_pkg::*;

    logic is_zero;

    assign ovf     = |spilled;
    assign is_zero = (merged == '0);
    assign cond    = cond_from(merged[W-1], is_zero, so);
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit #(
    parameter int unsigned W  = fsh_pkg::FSH_DEF_W,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  data_i,
    input  logic [W-1:0]  amt_i,
    input  logic [W-1:0]  fill_i,
    input  logic          dir_right_i,
    input  logic          rec_en_i,
    input  logic          so_i,
    output logic [W-1:0]  result_o,
    output logic [W-1:0]  spill_o,
    output logic          ovf_o,
    output logic [3:0]    cond_o
);
    import fsh_pkg::*;

    sh_dir_e       dir;
    logic [AW-1:0] n;
    logic [AW-1:0] rot_amt;
    logic [W-1:0]  rotated;
    logic [W-1:0]  keep;
    logic [W-1:0]  merged;
    logic [W-1:0]  spilled;
    logic          ovf_nx;
    cond_t         cond_nx;
    cond_t         cond_q;
    logic          unused_amt_hi;

    assign dir           = sh_dir_e'(dir_right_i);
    assign n             = amt_i[AW-1:0];
    assign unused_amt_hi = ^amt_i[W-1:AW];

    // A right shift by n is a left rotate by W-n (modulo W).
    assign rot_amt = (dir == SH_LEFT) ? n : (AW'(0) - n);

    fsh_rotl #(.W(W), .AW(AW)) u_rotl (
        .din  (data_i),
        .amt  (rot_amt),
        .dout (rotated)
    );

    fsh_mask #(.W(W), .AW(AW)) u_mask (
        .n    (n),
        .dir  (dir),
        .keep (keep)
    );

    assign merged  = (rotated & keep) | (fill_i & ~keep);
    assign spilled = rotated & ~keep;

    fsh_flags #(.W(W)) u_flags (
        .merged  (merged),
        .spilled (spilled),
        .so      (so_i),
        .ovf     (ovf_nx),
        .cond    (cond_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            spill_o  <= '0;
            ovf_o    <= 1'b0;
            cond_q   <= '0;
        end else begin
            result_o <= merged;
            spill_o  <= spilled;
            ovf_o    <= ovf_nx;
            if (rec_en_i) begin
                cond_q <= cond_nx;
            end
        end
    end

    assign cond_o = cond_q;
endmodule

// File: rtl/fsh_checker.sv
module fsh_checker #(
    parameter int unsigned W  = fsh_pkg::FSH_DEF_W,
    parameter int unsigned AW = $clog2(W)
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  data_i,
    input logic [W-1:0]  amt_i,
    input logic          dir_right_i,
    input logic          rec_en_i,
    input logic          so_i,
    input logic [W-1:0]  result_o,
    input logic [W-1:0]  spill_o,
    input logic          ovf_o,
    input logic [3:0]    cond_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (result_o == '0 && spill_o == '0 && !ovf_o && cond_o == 4'd0));

    // R4: nothing above bit n-1 of the spill on a left shift
    p_left_spill_r4: assert property (@(posedge clk) disable iff (rst)
        !dir_right_i |=> ((spill_o >> $past(amt_i[AW-1:0])) == '0));

    // R6: nothing below bit 64-n of the spill on a right shift
    p_right_spill_r6: assert property (@(posedge clk) disable iff (rst)
        dir_right_i |=> ((spill_o << $past(amt_i[AW-1:0])) == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_o == (spill_o != '0));

    p_zero_count_r8: assert property (@(posedge clk) disable iff (rst)
        (amt_i[AW-1:0] == '0) |=> (result_o == $past(data_i) && spill_o == '0));

    p_cond_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        rec_en_i |=> ($countones(cond_o[3:1]) == 1 && cond_o[0] == $past(so_i)));

    p_cond_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rec_en_i |=> $stable(cond_o));
endmodule

bind funnel_shift_unit fsh_checker #(.W(W), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .data_i      (data_i),
    .amt_i       (amt_i),
    .dir_right_i (dir_right_i),
    .rec_en_i    (rec_en_i),
    .so_i        (so_i),
    .result_o    (result_o),
    .spill_o     (spill_o),
    .ovf_o       (ovf_o),
    .cond_o      (cond_o)
);

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] data_i = '0, amt_i = '0, fill_i = '0;
    logic        dir_right_i = 1'b0, rec_en_i = 1'b0, so_i = 1'b0;
    logic [63:0] result_o, spill_o;
    logic        ovf_o;
    logic [3:0]  cond_o;

    logic [63:0] c_data [NW];
    logic [63:0] c_fill [NW];
    logic [63:0] c_res  [NW];
    logic [63:0] c_spill[NW];
    logic        c_ovf  [NW];
    logic [3:0]  c_cond [NW];

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] exp_cond = 4'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    funnel_shift_unit u_funnel_shift_unit (
        .clk(clk), .rst(rst), .data_i(data_i), .amt_i(amt_i), .fill_i(fill_i),
        .dir_right_i(dir_right_i), .rec_en_i(rec_en_i), .so_i(so_i),
        .result_o(result_o), .spill_o(spill_o), .ovf_o(ovf_o), .cond_o(cond_o)
    );

    for (genvar w = 0; w < NW; w++) begin : g_chain
        funnel_shift_unit u_word (
            .clk(clk), .rst(rst), .data_i(c_data[w]), .amt_i(amt_i), .fill_i(c_fill[w]),
            .dir_right_i(dir_right_i), .rec_en_i(1'b0), .so_i(1'b0),
            .result_o(c_res[w]), .spill_o(c_spill[w]), .ovf_o(c_ovf[w]), .cond_o(c_cond[w])
        );
    end

    // Behavioural reference: wide shift through a 128-bit window
    task automatic ref_shift(input logic [63:0] d, input logic [63:0] amt, input logic [63:0] f,
                             input logic right, output logic [63:0] r, output logic [63:0] s);
        int n;
        logic [127:0] wide;
        logic [63:0] low_ones;
        n = int'(amt[5:0]);
        low_ones = (64'd1 << n) - 64'd1;
        if (!right) begin
            wide = {64'd0, d} << n;
            r = wide[63:0] | (f & low_ones);
            s = wide[127:64];
        end else begin
            wide = {d, 64'd0} >> n;
            r = wide[127:64] | (f & ~({64{1'b1}} >> n));
            s = wide[63:0];
        end
    endtask

    task automatic check(input string tag, input logic [63:0] er, input logic [63:0] es,
                         input logic eo, input logic [3:0] ec);
        n_chk++;
        if (result_o !== er || spill_o !== es || ovf_o !== eo || cond_o !== ec) begin
            n_bad++;
            $display("FAIL %s: res=%h spill=%h ovf=%b cond=%b expected res=%h spill=%h ovf=%b cond=%b",
                     tag, result_o, spill_o, ovf_o, cond_o, er, es, eo, ec);
        end
    endtask

    // Drive one operation, wait one edge, compare with the model
    task automatic apply(input string tag, input logic [63:0] d, input logic [63:0] amt,
                         input logic [63:0] f, input logic right, input logic rec, input logic so);
        logic [63:0] er, es;
        data_i = d; amt_i = amt; fill_i = f;
        dir_right_i = right; rec_en_i = rec; so_i = so;
        ref_shift(d, amt, f, right, er, es);
        if (rec) exp_cond = {er[63], (!er[63] && er != 0), (er == 0), so};
        @(posedge clk); #1;
        check(tag, er, es, (es != 0), exp_cond);
    endtask

    task automatic chain_trial(input logic [255:0] big, input int n, input logic right);
        logic [255:0] expv, got;
        amt_i = 64'(n); dir_right_i = right; rec_en_i = 1'b0;
        for (int w = 0; w < NW; w++) begin
            c_data[w] = big[64*w +: 64];
            c_fill[w] = '0;
        end
        @(posedge clk); #1;
        for (int w = 0; w < NW; w++) begin
            if (!right) c_fill[w] = (w == 0) ? 64'd0 : c_spill[w-1];
            else        c_fill[w] = (w == NW-1) ? 64'd0 : c_spill[w+1];
        end
        @(posedge clk); #1;
        for (int w = 0; w < NW; w++) got[64*w +: 64] = c_res[w];
        expv = right ? (big >> n) : (big << n);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL R11: n=%0d right=%b got=%h expected=%h", n, right, got, expv);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d, f, a;
        for (int w = 0; w < NW; w++) begin
            c_data[w] = '0;
            c_fill[w] = '0;
        end
        // R1: reset dominates non-trivial inputs
        data_i = 64'hDEAD_BEEF_0123_4567; amt_i = 64'd9; fill_i = '1;
        rec_en_i = 1'b1; so_i = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", 64'd0, 64'd0, 1'b0, 4'd0);
        rst = 1'b0;
        exp_cond = 4'd0;

        apply("R3/R4 left n=8", 64'hF123_4567_89AB_CDEF, 64'd8, 64'hFFFF_FFFF_FFFF_FF5A, 1'b0, 1'b1, 1'b0);
        apply("R5/R6 right n=8", 64'h0123_4567_89AB_CDEF, 64'd8, 64'hA5FF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1);
        apply("R8 left n=0", 64'h8000_0000_0000_0001, 64'd0, '1, 1'b0, 1'b1, 1'b0);
        apply("R8 right n=0", 64'h7000_0000_0000_0001, 64'd0, '1, 1'b1, 1'b0, 1'b0);
        apply("R2 upper count bits ignored", 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFC5, 64'd0, 1'b0, 1'b0, 1'b0);
        apply("R2 upper count bits ignored right", 64'h0000_FFFF_0000_FFFF, 64'h8000_0000_0000_0045, 64'd0, 1'b1, 1'b1, 1'b0);
        apply("R3/R7 left n=63", 64'h3, 64'd63, 64'h1234, 1'b0, 1'b1, 1'b0);
        apply("R5/R7 right n=63", 64'hC000_0000_0000_0000, 64'd63, 64'h0, 1'b1, 1'b1, 1'b1);
        apply("R9 zero result", 64'd0, 64'd4, 64'd0, 1'b0, 1'b1, 1'b0);
        apply("R10 hold cond", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0, 1'b0, 1'b1);
        apply("R7 no spill", 64'h0000_0000_0000_00FF, 64'd12, 64'd0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 60; i++) begin
            d = {$urandom, $urandom};
            f = {$urandom, $urandom};
            a = {$urandom, $urandom};
            apply((i % 2 == 0) ? "R3/R4/R9/R10 random left" : "R5/R6/R9/R10 random right",
                  d, a, f, 1'(i % 2), 1'($urandom % 2), 1'($urandom % 2));
        end

        chain_trial({4{64'h8123_4567_89AB_CDEF}}, 0, 1'b0);
        chain_trial({4{64'h8123_4567_89AB_CDEF}}, 63, 1'b1);
        for (int i = 0; i < 30; i++) begin
            chain_trial({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
                        int'($urandom % 64), 1'(i % 2));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule